// File: doc/BRIEF.md
# Clock-Ready Interrupt Register

This block is the interrupt register of a clock controller. It watches six oscillator or PLL ready inputs and one crystal-failure input, and it latches a sticky flag for each event. Each ready source has its own enable bit. Software reads the flags and the enables through one 32-bit register on a simple synchronous register bus. It clears flags by writing ones to a bank of clear bits. A single interrupt line is high whenever any flag is set.

The ready inputs are indexed as follows: 0 slow internal oscillator, 1 slow external oscillator, 2 fast internal oscillator, 3 fast external oscillator, 4 PLL lock, 5 auxiliary (converter) oscillator. The auxiliary oscillator can be started in two ways: by software, or by a peripheral that requests its clock. A ready flag for it is latched only when software started it, which is signalled by `aux_sw_on_i`. The crystal-failure flag has no enable bit and cannot be masked.

Top module: `clk_rdy_irq`

## Requirements
- R1: After reset the register reads 0x0000_0000 and `irq_o` is 0.
- R2: Bits 13:8 are the enables for ready sources 5..0, with bit 8+n belonging to source n (1 = enabled). They are read/write.
- R3: These bits always read 0, whatever was written to them: 6, 15:14, 23:16 and 31:24.
- R4: Ready flag n sits at bit n (n = 0..5). It is set on the clock edge where `rdy_i[n]` is high after having been low on the previous edge, provided enable n is set. It then stays set. A ready input that stays high does not set the flag again.
- R5: A rising ready input whose enable is clear leaves its flag at 0.
- R6: Ready flag 5 is set only if `aux_sw_on_i` is high on the same edge as the rising ready input. If the oscillator runs only because a peripheral requested it, no flag is set and no interrupt is raised.
- R7: Bit 7 is set on every edge where `xtal_fail_i` is high, independently of all enables. It stays set until cleared.
- R8: Writing 1 to bit 16+n clears flag n, and bit 23 clears flag 7. Writing 0 to a clear bit leaves its flag unchanged.
- R9: When a clear and a set reach the same flag on the same edge, the flag ends at 0.
- R10: `irq_o` is the OR of all flags and changes on the same edge as they do.
- R11: A write to any address other than `REG_ADDR` changes nothing. A read at any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| addr_i | input | ADDR_W | Register address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational from `addr_i`) |
| rdy_i | input | 6 | Synchronous ready levels, index order as listed above |
| aux_sw_on_i | input | 1 | Auxiliary oscillator switched on by software |
| xtal_fail_i | input | 1 | External crystal failure detected |
| irq_o | output | 1 | Combined interrupt |

## Verification
Every result is due one clock edge after its cause. A ready rise, a failure level, or a write presented before edge k shows up in the flags, the enables and `irq_o` just after edge k. The read path is combinational, so a read needs no extra cycle. The bench drives all inputs on the falling edge and samples on the next falling edge, which is exactly one rising edge later. Each check therefore lands in the first cycle where its result is valid. For the edge-detection checks, the ready inputs are held low for at least one rising edge before they are raised.

// File: rtl/crirq_pkg.sv
package crirq_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_RDY  = 6;
  localparam int AUX_IDX  = 5;
  localparam int FAIL_BIT = 7;
  localparam int FLAG_W   = 8;
  localparam int EN_LSB   = 8;
  localparam int CLR_LSB  = 16;
endpackage

// File: rtl/crirq_rise_det.sv
module crirq_rise_det #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] lvl_q, lvl_d;

  always_comb begin
    lvl_d = lvl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_d;
  end

  assign rise_o = lvl_i & ~lvl_q;

  // A held-high level must not produce a rise on the following edge (R4)
  assert_no_repeat_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o != '0) |=> ((rise_o & $past(lvl_i)) == '0));
endmodule

// File: rtl/crirq_sticky.sv
module crirq_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set_i) flag_d = 1'b1;
    if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  assert_sticky_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  assert_set_takes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> flag_o);
  assert_clear_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !flag_o);
endmodule

// File: rtl/clk_rdy_irq.sv
module clk_rdy_irq
  import crirq_pkg::*;
#(
  parameter int              ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_RDY-1:0] rdy_i,
  input  logic              aux_sw_on_i,
  input  logic              xtal_fail_i,
  output logic              irq_o
);
  localparam int PAD_HI = DATA_W - EN_LSB - NUM_RDY;

  logic               sel, wr_hit;
  logic [NUM_RDY-1:0] en_q, en_d;
  logic [NUM_RDY-1:0] rise;
  logic [FLAG_W-1:0]  clr, set, flags;

  assign sel    = (addr_i == REG_ADDR);
  assign wr_hit = wr_en_i && sel;

  // enable register: separate next-state and storage
  always_comb begin
    en_d = en_q;
    if (wr_hit) en_d = wdata_i[EN_LSB +: NUM_RDY];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_d;
  end

  assign clr = wr_hit ? wdata_i[CLR_LSB +: FLAG_W] : '0;

  crirq_rise_det #(.W(NUM_RDY)) u_rise (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (rdy_i),
    .rise_o(rise)
  );

  // set conditions: per-source variant chosen by generate
  for (genvar i = 0; i < NUM_RDY; i++) begin : g_set
    if (i == AUX_IDX) begin : g_aux
      assign set[i] = rise[i] && en_q[i] && aux_sw_on_i;
    end else begin : g_std
      assign set[i] = rise[i] && en_q[i];
    end
  end
  for (genvar j = NUM_RDY; j < FLAG_W; j++) begin : g_set_hi
    if (j == FAIL_BIT) begin : g_fail
      assign set[j] = xtal_fail_i;
    end else begin : g_rsvd
      assign set[j] = 1'b0;
    end
  end

  for (genvar k = 0; k < FLAG_W; k++) begin : g_flag
    if (k < NUM_RDY || k == FAIL_BIT) begin : g_cell
      crirq_sticky u_cell (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .set_i (set[k]),
        .clr_i (clr[k]),
        .flag_o(flags[k])
      );
    end else begin : g_none
      assign flags[k] = 1'b0;
    end
  end

  assign irq_o   = |flags;
  assign rdata_o = sel ? {{PAD_HI{1'b0}}, en_q, flags} : '0;

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[DATA_W-1:CLR_LSB+FLAG_W],
                          wdata_i[CLR_LSB-1:EN_LSB+NUM_RDY], clr[NUM_RDY], set[NUM_RDY]};

  for (genvar m = 0; m < NUM_RDY; m++) begin : g_chk
    assert_no_set_disabled_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flags[m] && !en_q[m]) |=> !flags[m]);
  end

  assert_aux_needs_sw_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flags[AUX_IDX] && !aux_sw_on_i) |=> !flags[AUX_IDX]);
  assert_fail_unmasked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xtal_fail_i && !clr[FAIL_BIT]) |=> flags[FAIL_BIT]);
  assert_foreign_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !sel) |=> $stable(en_q));
  assert_irq_follows_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (rdata_o[FLAG_W-1:0] != '0 || !sel));
endmodule

// File: tb/clk_rdy_irq_test.sv
module clk_rdy_irq_test;
  localparam logic [3:0] REG = 4'h0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = REG;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  rdy = '0;
  logic        aux_sw = 1'b0;
  logic        fail = 1'b0;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  clk_rdy_irq uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .rdy_i(rdy), .aux_sw_on_i(aux_sw),
    .xtal_fail_i(fail), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = REG;
    #1;
  endtask

  task automatic rd_check(input string req, input logic [31:0] exp);
    addr = REG;
    #1;
    check(req, rdata, exp);
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] ef;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_check("R1 reset read", 32'h0);
    check("R1 reset irq", {31'b0, irq}, 32'h0);

    // R3 reserved bits, R2 enables readback
    wr(REG, 32'hFFFF_FFFF);
    rd_check("R3 reserved zero / R2 enables", 32'h0000_3F00);
    wr(REG, 32'h0000_1500);
    rd_check("R2 enable pattern", 32'h0000_1500);

    // R11 foreign address
    wr(4'h3, 32'h00FF_3F00);
    rd_check("R11 foreign write ignored", 32'h0000_1500);
    addr = 4'h3; #1;
    check("R11 foreign read zero", rdata, 32'h0);
    addr = REG;

    // Sweep enables x software-on with all ready inputs rising: R4 R5 R6 R8 R10
    for (int en = 0; en < 64; en++) begin
      for (int sw = 0; sw < 2; sw++) begin
        wr(REG, 32'h00FF_0000 | (32'(en) << 8));
        aux_sw = sw[0];
        rdy = 6'h3F;
        @(negedge clk); #1;
        ef = {26'b0, en[5] & sw[0], en[4:0]};
        rd_check("R4/R5/R6 flags after rise", (32'(en) << 8) | ef);
        check("R10 irq", {31'b0, irq}, {31'b0, ef != 0});
        wr(REG, 32'h003F_0000 | (32'(en) << 8));
        rd_check("R8/R4 cleared, held level no reset", 32'(en) << 8);
        rdy = '0; aux_sw = 1'b0;
        @(negedge clk);
      end
    end

    // R7 failure flag unmasked, R8 clear-by-zero ignored, clear by one
    wr(REG, 32'h00FF_0000);
    fail = 1'b1;
    @(negedge clk); #1;
    rd_check("R7 fail flag with enables off", 32'h0000_0080);
    check("R7/R10 irq from fail", {31'b0, irq}, 32'h1);
    fail = 1'b0;
    wr(REG, 32'h007F_0000);
    rd_check("R8 other clears leave fail flag", 32'h0000_0080);
    wr(REG, 32'h0080_0000);
    rd_check("R8 fail cleared", 32'h0);
    check("R10 irq low", {31'b0, irq}, 32'h0);

    // R9 clear and set on the same edge
    wr(REG, 32'h0000_0100);
    @(negedge clk);
    addr = REG; wdata = 32'h0001_0100; wr_en = 1'b1; rdy = 6'h01;
    @(negedge clk);
    wr_en = 1'b0; #1;
    rd_check("R9 clear wins over set", 32'h0000_0100);
    rdy = '0;
    @(negedge clk);
    rdy = 6'h01;
    @(negedge clk); #1;
    rd_check("R4 flag 0 set", 32'h0000_0101);
    rdy = '0;
    wr(REG, 32'h0000_0100);
    rd_check("R8 zero clear keeps flag", 32'h0000_0101);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule